// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor through two separate request outputs: a normal request and a fast request. Each output has its own bank of per-line settings. Every line can be qualified as level-sensitive or edge-sensitive, with either polarity, and then gated by an enable bit. Edge events are held in sticky pending bits until software acknowledges them. Level lines simply track the input.

Software programs and inspects both banks through a small word-wide register bus with a combinational read path. Each bank exposes a raw view of its lines after polarity correction and a masked status view. A request output is high whenever its status view is nonzero. All inputs are synchronised to the block clock first, so they may come from any clock domain.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset every register of both banks reads zero, and both request outputs are low.
- R2: Byte address bit 5 selects the bank (0 normal, 1 fast). Address bits 4:2 select the register: 0 source, 1 enable mask, 2 clear, 3 mode, 4 polarity, 5 status. Mask, mode and polarity read back what was written. Source and status ignore writes, and clear reads as zero.
- R3: A line whose mode bit is 0 is level-sensitive. It is pending while its input is high when its polarity bit is 0, and while its input is low when its polarity bit is 1.
- R4: A line whose mode bit is 1 is edge-sensitive. A rising edge (polarity 0) or a falling edge (polarity 1) sets a pending bit. That bit stays set after the input returns.
- R5: A write to a bank's clear register removes the edge pending bits at the 1 positions of the written word. Lines at the 0 positions keep their state.
- R6: A clear write leaves no lasting effect on a level-sensitive line: it stays pending while its input is active.
- R7: If an edge of the selected polarity is detected in the same cycle as a clear write for that line, the line remains pending.
- R8: The status register equals the pending vector ANDed with the enable mask. A masked edge line keeps its pending bit and shows again when it is unmasked.
- R9: The source register reads the synchronised inputs XORed with the bank's polarity register.
- R10: Each request output is registered. It is high one cycle after its bank's status becomes nonzero, and low one cycle after the status becomes zero.
- R11: The two banks are independent: settings and pending state of one bank never affect the other bank's status or output.
- R12: An input change reaches the source register after exactly two clock edges, through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt request lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The delicate overlap is a clear write to an edge line landing in the very cycle its synchroniser presents a fresh edge. The bench first leaves the line pending and drops the input. It then raises the input again and issues the clear write exactly two falling clock edges later, so that the write and the detected edge are sampled on the same rising edge. The line must still read pending afterwards, and a later clear with no edge must still clear it. This shows that the new edge takes priority over the acknowledge, rather than the clear simply failing.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int NUM_LINES = 32;
    localparam int ADDR_W    = 6;
    localparam int BANK_BIT  = 5;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        RSEL_SRC  = 3'd0,
        RSEL_MASK = 3'd1,
        RSEL_CLR  = 3'd2,
        RSEL_MODE = 3'd3,
        RSEL_POL  = 3'd4,
        RSEL_STAT = 3'd5
    } rsel_e;

    typedef struct packed {
        logic mask;
        logic mode;
        logic pol;
        logic clr;
    } bank_we_t;

    function automatic logic [2:0] reg_of(input logic [ADDR_W-1:0] a);
        return a[4:2];
    endfunction

    function automatic bank_we_t decode_we(input logic wr_hit, input logic [2:0] r);
        bank_we_t w;
        w.mask = wr_hit && (r == RSEL_MASK);
        w.mode = wr_hit && (r == RSEL_MODE);
        w.pol  = wr_hit && (r == RSEL_POL);
        w.clr  = wr_hit && (r == RSEL_CLR);
        return w;
    endfunction

endpackage

// File: rtl/dirq_sync.sv
module dirq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign q      = chain[STAGES-1];
    assign q_prev = prev_q;
endmodule

// File: rtl/dirq_bank.sv
module dirq_bank
    import dirq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prv,
    input  bank_we_t     we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] src,
    output logic [W-1:0] status,
    output logic [W-1:0] pend_e,
    output logic [W-1:0] hit,
    output logic         req
);
    logic [W-1:0] clr;
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else begin
            if (we.mask) mask_q <= wdata;
            if (we.mode) mode_q <= wdata;
            if (we.pol)  pol_q  <= wdata;
        end
    end

    assign clr = we.clr ? wdata : '0;
    assign src = cur ^ pol_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        logic rise, fall, pe_q;
        assign rise   = cur[i] & ~prv[i];
        assign fall   = ~cur[i] & prv[i];
        assign hit[i] = mode_q[i] & (pol_q[i] ? fall : rise);

        always_ff @(posedge clk) begin
            if (rst || !mode_q[i]) pe_q <= 1'b0;
            else                   pe_q <= hit[i] | (pe_q & ~clr[i]);
        end
        assign pend_e[i] = pe_q;
    end

    assign pend   = (mode_q & pend_e) | (~mode_q & src);
    assign status = pend & mask_q;

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= |status;
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import dirq_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [N-1:0] cur, prv;
    logic [2:0]   rsel;
    logic         wr_hit;
    bank_we_t     we_n, we_f;

    logic [N-1:0] n_mask, n_mode, n_pol, n_src, n_stat, n_pe, n_hit;
    logic [N-1:0] f_mask, f_mode, f_pol, f_src, f_stat, f_pe, f_hit;
    logic [N-1:0] sel_mask, sel_mode, sel_pol, sel_src, sel_stat;

    dirq_sync #(.W(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .d(irq_in), .q(cur), .q_prev(prv)
    );

    assign rsel   = reg_of(bus_addr);
    assign wr_hit = bus_sel && bus_wr;
    assign we_n   = decode_we(wr_hit && !bus_addr[BANK_BIT], rsel);
    assign we_f   = decode_we(wr_hit &&  bus_addr[BANK_BIT], rsel);

    dirq_bank #(.W(N)) u_nbank (
        .clk(clk), .rst(rst), .cur(cur), .prv(prv), .we(we_n), .wdata(bus_wdata),
        .mask_q(n_mask), .mode_q(n_mode), .pol_q(n_pol), .src(n_src),
        .status(n_stat), .pend_e(n_pe), .hit(n_hit), .req(irq_o)
    );

    dirq_bank #(.W(N)) u_fbank (
        .clk(clk), .rst(rst), .cur(cur), .prv(prv), .we(we_f), .wdata(bus_wdata),
        .mask_q(f_mask), .mode_q(f_mode), .pol_q(f_pol), .src(f_src),
        .status(f_stat), .pend_e(f_pe), .hit(f_hit), .req(fiq_o)
    );

    assign sel_mask = bus_addr[BANK_BIT] ? f_mask : n_mask;
    assign sel_mode = bus_addr[BANK_BIT] ? f_mode : n_mode;
    assign sel_pol  = bus_addr[BANK_BIT] ? f_pol  : n_pol;
    assign sel_src  = bus_addr[BANK_BIT] ? f_src  : n_src;
    assign sel_stat = bus_addr[BANK_BIT] ? f_stat : n_stat;

    always_comb begin
        case (rsel)
            RSEL_SRC:  bus_rdata = sel_src;
            RSEL_MASK: bus_rdata = sel_mask;
            RSEL_MODE: bus_rdata = sel_mode;
            RSEL_POL:  bus_rdata = sel_pol;
            RSEL_STAT: bus_rdata = sel_stat;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [5:0]   bus_addr,
    input logic [N-1:0] bus_wdata,
    input logic         irq_o,
    input logic         fiq_o,
    input logic [N-1:0] n_stat,
    input logic [N-1:0] n_mask,
    input logic [N-1:0] f_stat,
    input logic [N-1:0] f_mask,
    input logic [N-1:0] f_mode,
    input logic [N-1:0] f_pe,
    input logic [N-1:0] f_hit
);
    logic [N-1:0] f_clr_seen;
    assign f_clr_seen = (bus_sel && bus_wr && bus_addr[5:2] == 4'b1010) ? bus_wdata : '0;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_o && !fiq_o));

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (rst)
        ((n_stat & ~n_mask) == '0) && ((f_stat & ~f_mask) == '0));

    assert_req_lag_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_o == $past(|n_stat)) && (fiq_o == $past(|f_stat)));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (($past(f_pe) & ~f_pe & f_mode & ~$past(f_clr_seen)) == '0));

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(f_hit) & f_mode & ~f_pe) == '0));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o), .fiq_o(fiq_o),
    .n_stat(n_stat), .n_mask(n_mask), .f_stat(f_stat), .f_mask(f_mask),
    .f_mode(f_mode), .f_pe(f_pe), .f_hit(f_hit)
);

// File: tb/dual_irq_ctrl_tb.sv
module dual_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    typedef struct packed {
        logic [31:0] pol;
        logic [31:0] mask;
        logic [31:0] din;
        logic [31:0] exp_src;
        logic [31:0] exp_stat;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_00F1, 32'h0000_00F1, 32'h0000_00F1},
        '{32'h0000_FFFF, 32'h0F0F_0F0F, 32'h1234_5678, 32'h1234_A987, 32'h0204_0907},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        '{32'h0000_0000, 32'h0000_0000, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: all registers zero after reset
        for (int a = 0; a < 2; a++) begin
            for (int r = 0; r < 6; r++) begin
                rd(6'(a * 32 + r * 4), v);
                check("R1 reset register", v, 32'h0);
            end
        end
        check("R1 reset outputs", {30'h0, irq_o, fiq_o}, 32'h0);

        // R2: readback and bank separation
        wr(6'h2C, 32'hDEAD_BEEF);
        rd(6'h2C, v); check("R2 fast mode readback", v, 32'hDEAD_BEEF);
        rd(6'h0C, v); check("R2 R11 normal mode untouched", v, 32'h0);
        wr(6'h2C, 32'h0);
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h14, v); check("R2 status ignores write", v, 32'h0);
        rd(6'h08, v); check("R2 clear reads zero", v, 32'h0);

        // R3 R8 R9: level-mode vector table on the normal bank
        foreach (VECS[k]) begin
            wr(6'h10, VECS[k].pol);
            wr(6'h04, VECS[k].mask);
            @(negedge clk) irq_in = VECS[k].din;
            settle(4);
            rd(6'h00, v); check("R9 source", v, VECS[k].exp_src);
            rd(6'h14, v); check("R3 R8 status", v, VECS[k].exp_stat);
            check("R10 irq level", {31'h0, irq_o}, {31'h0, |VECS[k].exp_stat});
            check("R11 fast quiet", {31'h0, fiq_o}, 32'h0);
        end

        // R12 R10: synchroniser and output latency
        wr(6'h10, 32'h0);
        wr(6'h04, 32'h1);
        @(negedge clk) irq_in = 32'h0;
        settle(4);
        @(negedge clk) irq_in = 32'h1;
        rd(6'h00, v); check("R12 one edge not visible", v, 32'h0);
        rd(6'h00, v); check("R12 two edges visible", v, 32'h1);
        check("R10 irq not yet", {31'h0, irq_o}, 32'h0);
        @(negedge clk); #1;
        check("R10 irq one cycle later", {31'h0, irq_o}, 32'h1);

        // R6: clear has no lasting effect on a level line
        wr(6'h08, 32'h1);
        settle(1);
        rd(6'h14, v); check("R6 level survives clear", v, 32'h1);
        @(negedge clk) irq_in = 32'h0;
        settle(3);
        rd(6'h14, v); check("R3 level drops", v, 32'h0);
        wr(6'h04, 32'h0);

        // R4 R5: edge mode on the fast bank
        @(negedge clk) irq_in = 32'h10;
        settle(4);
        wr(6'h30, 32'h10);
        wr(6'h2C, 32'h18);
        wr(6'h24, 32'h18);
        settle(2);
        rd(6'h34, v); check("R4 no edge yet", v, 32'h0);
        @(negedge clk) irq_in = 32'h18;
        settle(5);
        rd(6'h34, v); check("R4 rising edge pending", v, 32'h08);
        check("R11 fiq high", {31'h0, fiq_o}, 32'h1);
        check("R11 irq stays low", {31'h0, irq_o}, 32'h0);
        @(negedge clk) irq_in = 32'h10;
        settle(5);
        rd(6'h34, v); check("R4 sticky after release", v, 32'h08);
        @(negedge clk) irq_in = 32'h00;
        settle(5);
        rd(6'h34, v); check("R4 falling edge pending", v, 32'h18);
        rd(6'h20, v); check("R9 fast source", v, 32'h10);
        wr(6'h28, 32'h08);
        rd(6'h34, v); check("R5 partial clear", v, 32'h10);
        wr(6'h28, 32'h10);
        settle(1);
        rd(6'h34, v); check("R5 full clear", v, 32'h0);
        check("R10 fiq drops", {31'h0, fiq_o}, 32'h0);

        // R8: masked edge keeps its pending bit
        @(negedge clk) irq_in = 32'h08;
        settle(5);
        wr(6'h24, 32'h10);
        settle(1);
        rd(6'h34, v); check("R8 masked status", v, 32'h0);
        check("R8 masked fiq", {31'h0, fiq_o}, 32'h0);
        wr(6'h24, 32'h18);
        rd(6'h34, v); check("R8 unmasked pending", v, 32'h08);

        // R7: edge coincident with clear write
        @(negedge clk) irq_in = 32'h00;
        settle(5);
        @(negedge clk) irq_in = 32'h08;
        @(negedge clk);
        wr(6'h28, 32'h08);
        rd(6'h34, v); check("R7 edge beats clear", v, 32'h08);
        wr(6'h28, 32'h08);
        rd(6'h34, v); check("R7 later clear works", v, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule